// File: doc/BRIEF.md
# Active-Rule Sequencer with Selectable Antecedent Connective

This block sits between the fuzzification stage and the defuzzifier of a two-input fuzzy inference datapath. Each input arrives already fuzzified as two (label, degree) pairs, because the membership functions overlap in pairs. Only rules whose antecedents pair one active label of input 0 with one active label of input 1 can fire, so the block evaluates those four rules and skips the rest of the rule base.

After an inference is accepted, a two-bit rule counter drives one pair multiplexer per input and visits one label combination per clock. For each combination the two antecedent degrees are merged by the connective chosen at acceptance, either minimum or truncated product. The two labels are concatenated into a rule-memory address, and the consequent stored there is read out. The result is a burst of four beats, each carrying the activation degree, the consequent and the address used, with markers on the first and last beat. The rule memory is filled through a simple write port.

Top module: `ars_rule_sequencer`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_first` and `out_last` are 0 and `ready` is 1.
- R2: An accepted `start` produces exactly four `out_valid` beats on consecutive cycles. The first beat appears two clock edges after the accepting edge, and the cycle after the fourth beat has `out_valid` low.
- R3: `out_first` is 1 only on the first beat of a burst and `out_last` is 1 only on the fourth beat.
- R4: Beat k (k = 0..3) uses pair B of input 0 when bit 0 of k is 1 and pair A otherwise. It uses pair B of input 1 when bit 1 of k is 1 and pair A otherwise. The beat order is therefore (A0,A1), (B0,A1), (A0,B1), (B0,B1).
- R5: With `use_product` = 0 at acceptance, `out_act` is the smaller of the two selected degrees.
- R6: With `use_product` = 1 at acceptance, `out_act` is the upper DEG_W bits of the 2·DEG_W-bit product of the two selected degrees. Any result is at most the smaller degree.
- R7: `out_addr` equals {input-1 label, input-0 label}, with input 0 in the low LBL_W bits. `out_cons` on the same beat is the rule-memory word at that address.
- R8: `ready` is 1 exactly when no inference is in progress. It falls after an accepting edge and is 1 again on the cycle showing the fourth beat. A `start` while `ready` is 0 is ignored and neither adds beats nor restarts the burst.
- R9: A write with `cfg_we` = 1 stores `cfg_data` at `cfg_addr`, and later inferences addressing that word return the new value.
- R10: Labels, degrees and `use_product` are sampled at the accepting edge. Changes to them during the burst do not alter its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Rule memory write enable |
| cfg_addr | input | 2*LBL_W | Rule memory write address |
| cfg_data | input | CONS_W | Consequent word to write |
| start | input | 1 | Request a new inference |
| ready | output | 1 | Idle; a start is accepted on this cycle's edge |
| use_product | input | 1 | Connective: 1 product, 0 minimum |
| in0_lbl_a | input | LBL_W | Input 0, pair A label |
| in0_deg_a | input | DEG_W | Input 0, pair A degree |
| in0_lbl_b | input | LBL_W | Input 0, pair B label |
| in0_deg_b | input | DEG_W | Input 0, pair B degree |
| in1_lbl_a | input | LBL_W | Input 1, pair A label |
| in1_deg_a | input | DEG_W | Input 1, pair A degree |
| in1_lbl_b | input | LBL_W | Input 1, pair B label |
| in1_deg_b | input | DEG_W | Input 1, pair B degree |
| out_valid | output | 1 | Beat valid |
| out_first | output | 1 | First beat of a burst |
| out_last | output | 1 | Fourth beat of a burst |
| out_act | output | DEG_W | Rule activation degree |
| out_cons | output | CONS_W | Consequent parameter read from the rule memory |
| out_addr | output | 2*LBL_W | Rule address of this beat |

## Verification
The bench runs many inferences in both connective modes. Degrees include zero and full scale, where a product that rounds up instead of truncating shows up as 255 instead of 254. Labels are varied so that swapped address fields or a reversed counter-to-input mapping give wrong addresses and consequents on the middle two beats. Half of the runs keep `start` asserted and scramble every input and the mode during the burst. A design that re-samples its inputs or accepts a start while busy then emits altered degrees or a fifth beat. One memory word is rewritten between inferences to confirm that the new consequent is returned.

// File: rtl/ars_pkg.sv
package ars_pkg;
  localparam int NUM_IN   = 2;
  localparam int RULES    = 4;
  localparam int IDX_W    = $clog2(RULES);

  typedef enum logic {
    CONN_MIN  = 1'b0,
    CONN_PROD = 1'b1
  } conn_e;
endpackage

// File: rtl/ars_pair_mux.sv
module ars_pair_mux #(
  parameter int LBL_W = 3,
  parameter int DEG_W = 8
) (
  input  logic             pick_b,
  input  logic [LBL_W-1:0] lbl_a,
  input  logic [DEG_W-1:0] deg_a,
  input  logic [LBL_W-1:0] lbl_b,
  input  logic [DEG_W-1:0] deg_b,
  output logic [LBL_W-1:0] lbl_sel,
  output logic [DEG_W-1:0] deg_sel
);
  always_comb begin
    lbl_sel = pick_b ? lbl_b : lbl_a;
    deg_sel = pick_b ? deg_b : deg_a;
  end
endmodule

// File: rtl/ars_connective.sv
module ars_connective #(
  parameter int DEG_W = 8
) (
  input  ars_pkg::conn_e   mode,
  input  logic [DEG_W-1:0] d0,
  input  logic [DEG_W-1:0] d1,
  output logic [DEG_W-1:0] act
);
  function automatic logic [DEG_W-1:0] f_min(input logic [DEG_W-1:0] x,
                                               input logic [DEG_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [DEG_W-1:0] f_prod(input logic [DEG_W-1:0] x,
                                                input logic [DEG_W-1:0] y);
    logic [2*DEG_W-1:0] full;
    full = {{DEG_W{1'b0}}, x} * {{DEG_W{1'b0}}, y};
    return full[2*DEG_W-1:DEG_W];
  endfunction

  always_comb begin
    if (mode == ars_pkg::CONN_PROD) act = f_prod(d0, d1);
    else                            act = f_min(d0, d1);
  end
endmodule

// File: rtl/ars_rule_mem.sv
module ars_rule_mem #(
  parameter int ADDR_W = 6,
  parameter int CONS_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CONS_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CONS_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CONS_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/ars_rule_sequencer.sv
module ars_rule_sequencer #(
  parameter int NUM_MF = 8,
  parameter int DEG_W  = 8,
  parameter int CONS_W = 16,
  localparam int LBL_W = $clog2(NUM_MF),
  localparam int ADR_W = 2 * LBL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADR_W-1:0]  cfg_addr,
  input  logic [CONS_W-1:0] cfg_data,
  input  logic              start,
  output logic              ready,
  input  logic              use_product,
  input  logic [LBL_W-1:0]  in0_lbl_a,
  input  logic [DEG_W-1:0]  in0_deg_a,
  input  logic [LBL_W-1:0]  in0_lbl_b,
  input  logic [DEG_W-1:0]  in0_deg_b,
  input  logic [LBL_W-1:0]  in1_lbl_a,
  input  logic [DEG_W-1:0]  in1_deg_a,
  input  logic [LBL_W-1:0]  in1_lbl_b,
  input  logic [DEG_W-1:0]  in1_deg_b,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_last,
  output logic [DEG_W-1:0]  out_act,
  output logic [CONS_W-1:0] out_cons,
  output logic [ADR_W-1:0]  out_addr
);
  import ars_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RULES - 1);

  // captured antecedent pairs, one row per input
  logic [LBL_W-1:0] cap_lbl_a [NUM_IN];
  logic [LBL_W-1:0] cap_lbl_b [NUM_IN];
  logic [DEG_W-1:0] cap_deg_a [NUM_IN];
  logic [DEG_W-1:0] cap_deg_b [NUM_IN];
  conn_e            cap_mode;

  logic             busy;
  logic [IDX_W-1:0] rule_idx;

  // named internal events
  logic             accept;
  logic             rule_step;
  logic             rule_first;
  logic             rule_last;

  logic [LBL_W-1:0] sel_lbl [NUM_IN];
  logic [DEG_W-1:0] sel_deg [NUM_IN];
  logic [DEG_W-1:0] act_comb;
  logic [ADR_W-1:0] addr_comb;
  logic [DEG_W-1:0] sel_deg0;
  logic [DEG_W-1:0] sel_deg1;

  assign ready      = !busy;
  assign accept     = start && !busy;
  assign rule_step  = busy;
  assign rule_first = busy && (rule_idx == '0);
  assign rule_last  = busy && (rule_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rule_idx <= '0;
      cap_mode <= CONN_MIN;
      for (int i = 0; i < NUM_IN; i++) begin
        cap_lbl_a[i] <= '0;
        cap_lbl_b[i] <= '0;
        cap_deg_a[i] <= '0;
        cap_deg_b[i] <= '0;
      end
    end else if (accept) begin
      busy         <= 1'b1;
      rule_idx     <= '0;
      cap_mode     <= conn_e'(use_product);
      cap_lbl_a[0] <= in0_lbl_a;
      cap_lbl_b[0] <= in0_lbl_b;
      cap_deg_a[0] <= in0_deg_a;
      cap_deg_b[0] <= in0_deg_b;
      cap_lbl_a[1] <= in1_lbl_a;
      cap_lbl_b[1] <= in1_lbl_b;
      cap_deg_a[1] <= in1_deg_a;
      cap_deg_b[1] <= in1_deg_b;
    end else if (busy) begin
      rule_idx <= rule_idx + IDX_W'(1);
      if (rule_idx == LAST_IDX) busy <= 1'b0;
    end
  end

  // counter bit g steers the pair multiplexer of input g
  for (genvar g = 0; g < NUM_IN; g++) begin : g_sel
    ars_pair_mux #(.LBL_W(LBL_W), .DEG_W(DEG_W)) u_mux (
      .pick_b  (rule_idx[g]),
      .lbl_a   (cap_lbl_a[g]),
      .deg_a   (cap_deg_a[g]),
      .lbl_b   (cap_lbl_b[g]),
      .deg_b   (cap_deg_b[g]),
      .lbl_sel (sel_lbl[g]),
      .deg_sel (sel_deg[g])
    );
  end

  assign sel_deg0  = sel_deg[0];
  assign sel_deg1  = sel_deg[1];
  assign addr_comb = {sel_lbl[1], sel_lbl[0]};

  ars_connective #(.DEG_W(DEG_W)) u_conn (
    .mode (cap_mode),
    .d0   (sel_deg[0]),
    .d1   (sel_deg[1]),
    .act  (act_comb)
  );

  ars_rule_mem #(.ADDR_W(ADR_W), .CONS_W(CONS_W)) u_mem (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr (addr_comb),
    .rdata (out_cons)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_act   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= rule_step;
      out_first <= rule_first;
      out_last  <= rule_last;
      out_act   <= act_comb;
      out_addr  <= addr_comb;
    end
  end
endmodule

// File: rtl/ars_rule_sequencer_chk.sv
module ars_rule_sequencer_chk #(
  parameter int DEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ready,
  input logic             out_valid,
  input logic             out_first,
  input logic             out_last,
  input logic [DEG_W-1:0] out_act,
  input logic             rule_step,
  input logic [DEG_W-1:0] sel_deg0,
  input logic [DEG_W-1:0] sel_deg1
);
  p_beats_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  p_gap_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_marks_in_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid);

  p_first_not_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> !out_last);

  p_first_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> ##1 out_first);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  p_act_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rule_step |=> (out_act <= $past(sel_deg0) && out_act <= $past(sel_deg1)));
endmodule

bind ars_rule_sequencer ars_rule_sequencer_chk #(.DEG_W(DEG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ready     (ready),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_last  (out_last),
  .out_act   (out_act),
  .rule_step (rule_step),
  .sel_deg0  (sel_deg0),
  .sel_deg1  (sel_deg1)
);

// File: tb/ars_rule_sequencer_test.sv
module ars_rule_sequencer_test;
  localparam int NMF = 8;
  localparam int W   = 8;
  localparam int CW  = 16;
  localparam int LW  = 3;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_data;
  logic          start, ready, use_product;
  logic [LW-1:0] l0a, l0b, l1a, l1b;
  logic [W-1:0]  d0a, d0b, d1a, d1b;
  logic          out_valid, out_first, out_last;
  logic [W-1:0]  out_act;
  logic [CW-1:0] out_cons;
  logic [AW-1:0] out_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [CW-1:0] shadow [64];
  logic [31:0]   seed = 32'h1234_5678;

  always #5 clk = ~clk;

  ars_rule_sequencer #(.NUM_MF(NMF), .DEG_W(W), .CONS_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .start(start), .ready(ready),
    .use_product(use_product),
    .in0_lbl_a(l0a), .in0_deg_a(d0a), .in0_lbl_b(l0b), .in0_deg_b(d0b),
    .in1_lbl_a(l1a), .in1_deg_a(d1a), .in1_lbl_b(l1b), .in1_deg_b(d1b),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_act(out_act), .out_cons(out_cons), .out_addr(out_addr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic run_inf(input logic [LW-1:0] a0, b0, a1, b1,
                         input logic [W-1:0] x0, y0, x1, y1,
                         input bit prod, input bit garble);
    int dd0, dd1, ea, ead;
    logic [LW-1:0] s0, s1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle gap", out_valid, 0);
    chk(ready == 1'b1, "R8 ready when idle", ready, 1);
    l0a = a0; l0b = b0; l1a = a1; l1b = b1;
    d0a = x0; d0b = y0; d1a = x1; d1b = y1;
    use_product = prod; start = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R8 busy after accept", ready, 0);
    chk(out_valid == 1'b0, "R2 latency", out_valid, 0);
    start = garble;
    if (garble) begin  // R10: scramble everything while busy
      use_product = !prod;
      l0a = ~a0; l0b = ~b0; l1a = ~a1; l1b = ~b1;
      d0a = ~x0; d0b = ~y0; d1a = ~x1; d1b = ~y1;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s0  = k[0] ? b0 : a0;
      s1  = k[1] ? b1 : a1;
      dd0 = k[0] ? int'(y0) : int'(x0);
      dd1 = k[1] ? int'(y1) : int'(x1);
      ea  = prod ? ((dd0 * dd1) >> W) : ((dd0 < dd1) ? dd0 : dd1);
      ead = int'({s1, s0});
      chk(out_valid == 1'b1, "R2 beat valid", out_valid, 1);
      chk(out_first == (k == 0), "R3 first mark", out_first, (k == 0));
      chk(out_last == (k == 3), "R3 last mark", out_last, (k == 3));
      chk(int'(out_act) == ea, prod ? "R6 product R4 order" : "R5 minimum R4 order",
          out_act, ea);
      chk(int'(out_addr) == ead, "R7 address R4 order", out_addr, ead);
      chk(out_cons == shadow[ead], "R7 consequent", out_cons, shadow[ead]);
      chk(ready == (k == 3), "R8 ready timing", ready, (k == 3));
      if (k == 2) start = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    start = 1'b0; use_product = 1'b0;
    l0a = '0; l0b = '0; l1a = '0; l1b = '0;
    d0a = '0; d0b = '0; d1a = '0; d1b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_first == 1'b0 && out_last == 1'b0,
        "R1 outputs in reset", {out_valid, out_first, out_last}, 0);
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && ready == 1'b1, "R1 idle after reset",
        {out_valid, ready}, 1);

    // fill rule memory (R9)
    for (int a = 0; a < 64; a++) begin
      shadow[a] = CW'((a * 613 + 29) & 16'hFFFF);
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = shadow[a];
      @(negedge clk);
    end
    cfg_we = 1'b0;

    for (int i = 0; i < 128; i++) begin
      logic [31:0] r1, r2;
      logic [W-1:0] x0, y0, x1, y1;
      r1 = rnd(); r2 = rnd();
      x0 = r2[7:0]; y0 = r2[15:8]; x1 = r2[23:16]; y1 = r2[31:24];
      if (i % 8 == 0) begin x0 = '1; y0 = '1; x1 = '1; y1 = '1; end
      if (i % 8 == 1) begin x0 = '0; y1 = '0; end
      if (i % 8 == 2) begin x0 = '1; y0 = 8'd1; x1 = 8'd128; y1 = '1; end
      run_inf(r1[2:0], r1[5:3], r1[8:6], r1[11:9], x0, y0, x1, y1,
              i[0], i[1]);
    end

    // R9: rewrite one word, then address it
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'({3'd5, 3'd2}); cfg_data = 16'hBEEF;
    shadow[{3'd5, 3'd2}] = 16'hBEEF;
    @(negedge clk);
    cfg_we = 1'b0;
    run_inf(3'd2, 3'd3, 3'd5, 3'd6, 8'd200, 8'd55, 8'd90, 8'd165, 1'b0, 1'b0);
    run_inf(3'd2, 3'd3, 3'd5, 3'd6, 8'd200, 8'd55, 8'd90, 8'd165, 1'b1, 1'b1);

    @(negedge clk);
    chk(out_valid == 1'b0, "R2 no extra beat", out_valid, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule